// File: doc/BRIEF.md
# Prioritized Contention Access Arbiter

This block decides which of four traffic categories gets the next transmit opportunity during the part of a superframe that is open to contention. Each category has a pending flag and a burst duration. Each also has its own random backoff counter, and all four counters count down in parallel on idle slot ticks. A category whose counter has reached zero contends on the next idle tick. The highest category among those contenders wins, but only if its whole exchange fits in the time left in the current contention window. Categories that lose widen their contention window and draw a fresh random backoff.

The decision leaves the block as a single grant toward the framer, with a valid/ready handshake. The grant carries the winning category, a flag that asks for an RTS/CTS exchange before the data, and the medium reservation duration that goes with that exchange. While the grant waits for the framer, the whole contention process is frozen and the grant fields do not move. A slot scheduler elsewhere supplies a flag that is high when the current slot is neither beacon period nor reserved, together with the remaining window length. A carrier-sense input marks a busy medium.

Top module: `contention_arb`

## Requirements
- R1: After reset no grant is offered, every backoff counter is zero and every contention exponent sits at CW_MIN_EXP, so a category that becomes pending contends on the first qualifying tick.
- R2: Contention happens only on a cycle where `slot_tick` is high, `cs_busy` is low, `open_win` is high and no grant is outstanding. A resulting grant shows on the outputs one clock later.
- R3: Only pending categories take part. A pending category with a nonzero counter decrements it by one on each qualifying tick. A busy medium or a closed window freezes every counter. With nothing pending, no grant is produced.
- R4: Category index 3 has the highest priority and index 0 the lowest. Among pending categories with a zero counter whose exchange fits, the highest index wins.
- R5: A category fits when its needed time is at most `win_left`. The needed time is its duration, plus PROT_OVH when protection applies. A category that does not fit keeps its counter at zero and its window unchanged, and contends again on later ticks, for example once a new window reports more time.
- R6: Each fitting zero-counter category that loses raises its exponent by one, up to CW_MAX_EXP. It then loads a new backoff equal to pseudo-random bits masked to 2^exponent − 1, so its counter never exceeds 2^CW_MAX_EXP − 1.
- R7: When a grant is taken, the winning category's exponent returns to CW_MIN_EXP and it draws a new backoff masked to 2^CW_MIN_EXP − 1.
- R8: `gnt_rts` is 1 exactly when the winner's duration is at least PROT_THR. In that case `gnt_nav` equals the winner's duration, and otherwise it is 0.
- R9: Once `gnt_valid` is high it stays high, with `gnt_ac`, `gnt_rts` and `gnt_nav` unchanged, until a cycle with `gnt_ready` high. On that cycle the grant is consumed and `gnt_valid` falls on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_tick | input | 1 | One-cycle pulse per backoff slot |
| cs_busy | input | 1 | Carrier sense: medium busy |
| open_win | input | 1 | Current slot is open for contention |
| win_left | input | DUR_W | Time units left in the contention window |
| ac_pend | input | 4 | Per-category pending flags, bit k for category k |
| ac_dur | input | 4*DUR_W | Per-category burst duration, category k in bits [k*DUR_W +: DUR_W] |
| gnt_valid | output | 1 | Grant offered |
| gnt_ready | input | 1 | Framer accepts the grant |
| gnt_ac | output | 2 | Winning category index |
| gnt_rts | output | 1 | Start with an RTS/CTS exchange |
| gnt_nav | output | DUR_W | Reservation duration carried by the RTS, 0 without protection |

## Verification
The hard state to reach is a counter sitting above zero, because at reset every counter is zero and only a lost contention loads a random value. The stimulus forces that state with deliberate ties. Two categories become pending together. Or a top category is kept pending and granted over and over while a low one keeps losing, until its exponent reaches the cap. Since the exact backoff drawn is not predictable from the ports, the bench checks the observable bounds instead. A loser stays silent through busy ticks, and it wins within 2^exponent idle ticks once it is alone.

// File: rtl/contention_pkg.sv
package contention_pkg;
  localparam int NUM_AC = 4;
  localparam int AC_W   = 2;

  typedef enum logic [AC_W-1:0] {
    CAT_BULK  = 2'd0,
    CAT_BEST  = 2'd1,
    CAT_VIDEO = 2'd2,
    CAT_VOICE = 2'd3
  } cat_e;
endpackage

// File: rtl/contention_lfsr.sv
module contention_lfsr #(
  parameter int          W    = 16,
  parameter logic [15:0] TAPS = 16'hB400,
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= SEED[W-1:0];
    else if (q[0]) q <= (q >> 1) ^ TAPS[W-1:0];
    else q <= q >> 1;
  end
endmodule

// File: rtl/contention_backoff.sv
module contention_backoff #(
  parameter int MIN_EXP = 2,
  parameter int MAX_EXP = 4,
  localparam int BO_W  = MAX_EXP,
  localparam int EXP_W = $clog2(MAX_EXP + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pend,
  input  logic            step,
  input  logic            lose,
  input  logic            won,
  input  logic [BO_W-1:0] rnd,
  output logic            zero
);
  logic [EXP_W-1:0] exp_q, exp_nx;
  logic [BO_W-1:0]  bo_q;

  function automatic logic [BO_W-1:0] win_mask(input logic [EXP_W-1:0] e);
    logic [BO_W:0] m;
    m = ({{BO_W{1'b0}}, 1'b1} << e) - 1'b1;
    return m[BO_W-1:0];
  endfunction

  assign exp_nx = (exp_q >= EXP_W'(MAX_EXP)) ? EXP_W'(MAX_EXP) : exp_q + 1'b1;
  assign zero   = (bo_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exp_q <= EXP_W'(MIN_EXP);
      bo_q  <= '0;
    end else if (won) begin
      exp_q <= EXP_W'(MIN_EXP);
      bo_q  <= rnd & win_mask(EXP_W'(MIN_EXP));
    end else if (lose) begin
      exp_q <= exp_nx;
      bo_q  <= rnd & win_mask(exp_nx);
    end else if (step && pend && !zero) begin
      bo_q  <= bo_q - 1'b1;
    end
  end
endmodule

// File: rtl/contention_select.sv
module contention_select
  import contention_pkg::*;
#(
  parameter int DUR_W    = 10,
  parameter int PROT_THR = 100,
  parameter int PROT_OVH = 20
) (
  input  logic [NUM_AC-1:0]       pend,
  input  logic [NUM_AC-1:0]       zero,
  input  logic [NUM_AC*DUR_W-1:0] dur,
  input  logic [DUR_W-1:0]        win_left,
  output logic [NUM_AC-1:0]       elig,
  output logic                    any,
  output logic [AC_W-1:0]         win_idx,
  output logic                    win_rts,
  output logic [DUR_W-1:0]        win_dur
);
  logic [NUM_AC-1:0] rts;

  for (genvar k = 0; k < NUM_AC; k++) begin : g_cat
    logic [DUR_W-1:0] d;
    logic [DUR_W:0]   need;
    assign d      = dur[k*DUR_W +: DUR_W];
    assign rts[k] = ({1'b0, d} >= (DUR_W+1)'(PROT_THR));
    assign need   = {1'b0, d} + (rts[k] ? (DUR_W+1)'(PROT_OVH) : '0);
    assign elig[k] = pend[k] && zero[k] && (need <= {1'b0, win_left});
  end

  always_comb begin
    any     = 1'b0;
    win_idx = '0;
    for (int k = 0; k < NUM_AC; k++) begin
      if (elig[k]) begin
        any     = 1'b1;
        win_idx = AC_W'(k);
      end
    end
    win_rts = rts[win_idx];
    win_dur = dur[win_idx*DUR_W +: DUR_W];
  end
endmodule

// File: rtl/contention_arb.sv
module contention_arb
  import contention_pkg::*;
#(
  parameter int DUR_W      = 10,
  parameter int CW_MIN_EXP = 2,
  parameter int CW_MAX_EXP = 4,
  parameter int PROT_THR   = 100,
  parameter int PROT_OVH   = 20,
  localparam int BO_W   = CW_MAX_EXP,
  localparam int LFSR_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    slot_tick,
  input  logic                    cs_busy,
  input  logic                    open_win,
  input  logic [DUR_W-1:0]        win_left,
  input  logic [NUM_AC-1:0]       ac_pend,
  input  logic [NUM_AC*DUR_W-1:0] ac_dur,
  output logic                    gnt_valid,
  input  logic                    gnt_ready,
  output logic [AC_W-1:0]         gnt_ac,
  output logic                    gnt_rts,
  output logic [DUR_W-1:0]        gnt_nav
);
  logic [LFSR_W-1:0] rnd;
  logic [NUM_AC-1:0] zero, elig;
  logic              any, win_rts, arb_ev, take;
  logic [AC_W-1:0]   win_idx;
  logic [DUR_W-1:0]  win_dur;

  assign arb_ev = slot_tick && !cs_busy && open_win && !gnt_valid;
  assign take   = gnt_valid && gnt_ready;

  contention_lfsr #(.W(LFSR_W)) u_lfsr (.clk(clk), .rst_n(rst_n), .q(rnd));

  for (genvar k = 0; k < NUM_AC; k++) begin : g_bo
    localparam int OFS = (k * BO_W) % (LFSR_W - BO_W + 1);
    contention_backoff #(.MIN_EXP(CW_MIN_EXP), .MAX_EXP(CW_MAX_EXP)) u_bo (
      .clk  (clk),
      .rst_n(rst_n),
      .pend (ac_pend[k]),
      .step (arb_ev),
      .lose (arb_ev && any && elig[k] && (win_idx != AC_W'(k))),
      .won  (take && (gnt_ac == AC_W'(k))),
      .rnd  (rnd[OFS +: BO_W]),
      .zero (zero[k])
    );
  end

  contention_select #(.DUR_W(DUR_W), .PROT_THR(PROT_THR), .PROT_OVH(PROT_OVH)) u_sel (
    .pend    (ac_pend),
    .zero    (zero),
    .dur     (ac_dur),
    .win_left(win_left),
    .elig    (elig),
    .any     (any),
    .win_idx (win_idx),
    .win_rts (win_rts),
    .win_dur (win_dur)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_valid <= 1'b0;
      gnt_ac    <= '0;
      gnt_rts   <= 1'b0;
      gnt_nav   <= '0;
    end else if (take) begin
      gnt_valid <= 1'b0;
    end else if (arb_ev && any) begin
      gnt_valid <= 1'b1;
      gnt_ac    <= win_idx;
      gnt_rts   <= win_rts;
      gnt_nav   <= win_rts ? win_dur : '0;
    end
  end
endmodule

// File: rtl/contention_arb_chk.sv
module contention_arb_chk #(
  parameter int DUR_W    = 10,
  parameter int PROT_THR = 100
) (
  input logic             clk,
  input logic             rst_n,
  input logic             slot_tick,
  input logic             cs_busy,
  input logic             open_win,
  input logic [DUR_W-1:0] win_left,
  input logic [3:0]       ac_pend,
  input logic             gnt_valid,
  input logic             gnt_ready,
  input logic [1:0]       gnt_ac,
  input logic             gnt_rts,
  input logic [DUR_W-1:0] gnt_nav
);
  logic [3:0]       pend_q;
  logic [DUR_W-1:0] left_q;
  always_ff @(posedge clk) begin
    pend_q <= ac_pend;
    left_q <= win_left;
  end

  p_hold_bp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid && !gnt_ready |=> gnt_valid && $stable(gnt_ac) && $stable(gnt_rts) && $stable(gnt_nav));
  p_take_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid && gnt_ready |=> !gnt_valid);
  p_qual_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gnt_valid) |-> $past(slot_tick && !cs_busy && open_win));
  p_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gnt_valid) |-> pend_q[gnt_ac]);
  p_fit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gnt_valid) |-> gnt_nav <= left_q);
  p_rts_nav_r8: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid && gnt_rts |-> gnt_nav >= DUR_W'(PROT_THR));
  p_plain_nav_r8: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid && !gnt_rts |-> gnt_nav == '0);
endmodule

bind contention_arb contention_arb_chk #(.DUR_W(DUR_W), .PROT_THR(PROT_THR)) u_chk (
  .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick), .cs_busy(cs_busy),
  .open_win(open_win), .win_left(win_left), .ac_pend(ac_pend),
  .gnt_valid(gnt_valid), .gnt_ready(gnt_ready), .gnt_ac(gnt_ac),
  .gnt_rts(gnt_rts), .gnt_nav(gnt_nav)
);

// File: tb/contention_arb_tb.sv
module contention_arb_tb;
  localparam int DW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          slot_tick = 1'b0, cs_busy = 1'b0, open_win = 1'b0, gnt_ready = 1'b0;
  logic [DW-1:0] win_left = '0;
  logic [3:0]    ac_pend = '0;
  logic [4*DW-1:0] ac_dur = '0;
  logic          gnt_valid, gnt_rts;
  logic [1:0]    gnt_ac;
  logic [DW-1:0] gnt_nav;

  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  contention_arb #(.DUR_W(DW), .CW_MIN_EXP(0), .CW_MAX_EXP(3), .PROT_THR(100), .PROT_OVH(20)) u_dut (
    .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick), .cs_busy(cs_busy), .open_win(open_win),
    .win_left(win_left), .ac_pend(ac_pend), .ac_dur(ac_dur), .gnt_valid(gnt_valid),
    .gnt_ready(gnt_ready), .gnt_ac(gnt_ac), .gnt_rts(gnt_rts), .gnt_nav(gnt_nav));

  typedef struct packed {
    logic [3:0] pend; logic [9:0] dur; logic busy; logic open;
    logic [9:0] left; logic ev; logic [1:0] eac; logic ep;
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{4'b0001, 10'd50,  1'b0, 1'b1, 10'd200,  1'b1, 2'd0, 1'b0},
    '{4'b0100, 10'd99,  1'b0, 1'b1, 10'd99,   1'b1, 2'd2, 1'b0},
    '{4'b0100, 10'd99,  1'b0, 1'b1, 10'd98,   1'b0, 2'd0, 1'b0},
    '{4'b1000, 10'd100, 1'b0, 1'b1, 10'd120,  1'b1, 2'd3, 1'b1},
    '{4'b1000, 10'd100, 1'b0, 1'b1, 10'd119,  1'b0, 2'd0, 1'b0},
    '{4'b0010, 10'd60,  1'b1, 1'b1, 10'd200,  1'b0, 2'd0, 1'b0},
    '{4'b0010, 10'd60,  1'b0, 1'b0, 10'd200,  1'b0, 2'd0, 1'b0},
    '{4'b0000, 10'd10,  1'b0, 1'b1, 10'd200,  1'b0, 2'd0, 1'b0},
    '{4'b1010, 10'd150, 1'b0, 1'b1, 10'd160,  1'b0, 2'd0, 1'b0},
    '{4'b0010, 10'd999, 1'b0, 1'b1, 10'd1023, 1'b1, 2'd1, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input logic busy, input logic open);
    @(negedge clk); cs_busy = busy; open_win = open; slot_tick = 1'b1;
    @(negedge clk); slot_tick = 1'b0;
  endtask

  task automatic consume();
    @(negedge clk); gnt_ready = 1'b1;
    @(negedge clk); gnt_ready = 1'b0;
  endtask

  function automatic logic [4*DW-1:0] all_dur(input logic [DW-1:0] d);
    return {d, d, d, d};
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(gnt_valid == 1'b0, "R1 reset no grant", gnt_valid, 0);

    // Table walk: single contender per vector, so no counter leaves zero
    for (int i = 0; i < 10; i++) begin
      ac_pend = VEC[i].pend; ac_dur = all_dur(VEC[i].dur); win_left = VEC[i].left;
      tick(VEC[i].busy, VEC[i].open);
      chk(gnt_valid == VEC[i].ev, "R2/R3/R5 vector grant", gnt_valid, VEC[i].ev);
      if (VEC[i].ev) begin
        chk(gnt_ac == VEC[i].eac, "R4 vector category", gnt_ac, VEC[i].eac);
        chk(gnt_rts == VEC[i].ep, "R8 vector rts", gnt_rts, VEC[i].ep);
        chk(gnt_nav == (VEC[i].ep ? VEC[i].dur : 10'd0), "R8 vector nav", gnt_nav,
            VEC[i].ep ? VEC[i].dur : 0);
        consume();
        chk(gnt_valid == 1'b0, "R9 consumed", gnt_valid, 0);
      end
      ac_pend = '0;
    end

    // Back-pressure: grant frozen while ready low (R9)
    ac_pend = 4'b0100; ac_dur = all_dur(10'd150); win_left = 10'd500;
    tick(1'b0, 1'b1);
    chk(gnt_valid && gnt_ac == 2'd2 && gnt_rts, "R9 bp grant", gnt_ac, 2);
    ac_pend = 4'b1000;
    for (int i = 0; i < 4; i++) tick(1'b0, 1'b1);
    chk(gnt_valid == 1'b1, "R9 held valid", gnt_valid, 1);
    chk(gnt_ac == 2'd2 && gnt_nav == 10'd150, "R9 held fields", gnt_ac, 2);
    consume();
    tick(1'b0, 1'b1);
    chk(gnt_valid && gnt_ac == 2'd3, "R9 next after take", gnt_ac, 3);
    consume();

    // Fit skip: top category too long, lower one wins (R5, R4)
    ac_dur = {10'd200, 10'd10, 10'd10, 10'd30};
    ac_pend = 4'b1001; win_left = 10'd100;
    tick(1'b0, 1'b1);
    chk(gnt_valid && gnt_ac == 2'd0, "R5 non-fit skipped", gnt_ac, 0);
    consume();
    ac_pend = 4'b1000;
    tick(1'b0, 1'b1);
    chk(gnt_valid == 1'b0, "R5 still no fit", gnt_valid, 0);
    win_left = 10'd300;
    tick(1'b0, 1'b1);
    chk(gnt_valid && gnt_ac == 2'd3, "R5 retry in new window", gnt_ac, 3);
    chk(gnt_nav == 10'd200, "R8 nav of long burst", gnt_nav, 200);
    consume();

    // Tie: category 2 beats 1, loser backs off at most 1 slot (R4, R6, R3)
    ac_dur = all_dur(10'd20); win_left = 10'd500; ac_pend = 4'b0110;
    tick(1'b0, 1'b1);
    chk(gnt_valid && gnt_ac == 2'd2, "R4 tie priority", gnt_ac, 2);
    consume();
    ac_pend = 4'b0010;
    for (int i = 0; i < 3; i++) tick(1'b1, 1'b1);
    chk(gnt_valid == 1'b0, "R3 busy freezes", gnt_valid, 0);
    begin
      int n = 0;
      for (int i = 1; i <= 4 && n == 0; i++) begin
        tick(1'b0, 1'b1);
        if (gnt_valid) n = i;
      end
      chk(n >= 1 && n <= 2 && gnt_ac == 2'd1, "R6 loser backoff bound", n, 2);
    end
    consume();

    // Cap: category 0 loses repeatedly; category 3 resets to min each time (R7, R6)
    ac_pend = 4'b1001;
    begin
      int bad = 0;
      for (int i = 0; i < 30; i++) begin
        tick(1'b0, 1'b1);
        if (!(gnt_valid && gnt_ac == 2'd3)) bad++;
        consume();
      end
      chk(bad == 0, "R7 winner redraws minimum", bad, 0);
    end
    ac_pend = 4'b0001;
    begin
      int n = 0;
      for (int i = 1; i <= 12 && n == 0; i++) begin
        tick(1'b0, 1'b1);
        if (gnt_valid) n = i;
      end
      chk(n >= 1 && n <= 8 && gnt_ac == 2'd0, "R6 capped window bound", n, 8);
    end
    consume();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule